// File: doc/BRIEF.md
# Rotating-Priority Internal Interrupt Aggregator

This block gathers a parameterised set of level-style peripheral interrupt lines (32 by default) into one summary interrupt for a processor. Each line is paired with an enable bit in a mask register. A source counts as pending only while its line is high and its enable bit is set. The summary output is the registered OR of all pending sources.

Software reads and updates the mask through a small register port. That port supports a whole-word write, a set-bits operation and a clear-bits operation. To service interrupts, software raises a one-cycle dispatch request, and the block answers with exactly one pending source index. The index is not chosen by fixed priority. The search starts at a saved pointer and walks upward, wrapping from the top index back to zero. After each serve, the pointer moves to one place past the index just served, so a busy low-numbered source cannot starve the others.

Two equivalent search structures are offered through a parameter: a rotate-and-scan loop and a doubled-vector scan.

Top module: `rr_irq_agg`

## Requirements
- R1: After reset the mask register is all zeros, the search pointer is zero, and irq_out, disp_valid, disp_found and disp_idx are all low.
- R2: A source is pending only when its src_lvl bit and its mask bit are both 1. A source whose mask bit is 0 is never reported and never raises irq_out.
- R3: irq_out equals the OR of the pending bits as they stood one clock earlier.
- R4: A dispatch_req sampled high at a clock edge makes disp_valid high for exactly the following cycle. disp_valid is low after any edge where dispatch_req was low.
- R5: A dispatch reports the first pending index met when scanning upward from the search pointer, modulo NUM_SRC.
- R6: After a successful dispatch of index k, the search pointer becomes k+1, or 0 when k is NUM_SRC-1.
- R7: A dispatch with nothing pending gives disp_valid=1, disp_found=0 and disp_idx=0, and leaves the search pointer unchanged.
- R8: When mask_we is high, mask_op selects the update: 2'b00 loads mask_wdata, 2'b01 sets the bits that are 1 in mask_wdata, 2'b10 clears the bits that are 1 in mask_wdata, and 2'b11 changes nothing. Bits not selected keep their value. mask_rdata always shows the current mask.
- R9: Source lines are not latched. A line that drops before the request edge is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | NUM_SRC | Peripheral interrupt levels |
| mask_we | input | 1 | Mask update strobe |
| mask_op | input | 2 | Mask update kind (write/set/clear/none) |
| mask_wdata | input | NUM_SRC | Mask update operand |
| mask_rdata | output | NUM_SRC | Current mask value |
| dispatch_req | input | 1 | Request one dispatch |
| disp_valid | output | 1 | Dispatch answer present |
| disp_found | output | 1 | A source was selected |
| disp_idx | output | IDX_W | Selected source index |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
The bench builds two copies of the block at the default width of 32 sources: one with the rotate-and-scan picker (PICK_IMPL=0) and one with the doubled-vector picker (PICK_IMPL=1). Both copies are compared against one behavioural model on every clock. The full width makes the wrap from index 31 back to 0 reachable. It also makes clear-bit updates that touch one bit among many observable. Having both picker variants side by side shows that they agree under the same long random stream of sources, mask updates and requests.

// File: rtl/rr_irq_pkg.sv
package rr_irq_pkg;
   typedef enum logic [1:0] {
      MOP_LOAD  = 2'b00,
      MOP_SET   = 2'b01,
      MOP_CLEAR = 2'b10,
      MOP_NONE  = 2'b11
   } mask_op_e;
endpackage

// File: rtl/rr_irq_mask_reg.sv
module rr_irq_mask_reg #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [1:0]         op,
   input  logic [NUM_SRC-1:0] wdata,
   output logic [NUM_SRC-1:0] mask_q
);
   import rr_irq_pkg::*;

   logic [NUM_SRC-1:0] mask_d;
   mask_op_e           op_e;

   assign op_e = mask_op_e'(op);

   always_comb begin
      mask_d = mask_q;
      if (we) begin
         unique case (op_e)
            MOP_LOAD:  mask_d = wdata;
            MOP_SET:   mask_d = mask_q | wdata;
            MOP_CLEAR: mask_d = mask_q & ~wdata;
            default:   mask_d = mask_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_d;
   end
endmodule

// File: rtl/rr_irq_picker.sv
module rr_irq_picker #(
   parameter int NUM_SRC   = 32,
   parameter int PICK_IMPL = 0,
   localparam int IDX_W    = $clog2(NUM_SRC),
   localparam int DBL_W    = 2 * NUM_SRC,
   localparam int DBL_IW   = $clog2(DBL_W)
) (
   input  logic [NUM_SRC-1:0] pend,
   input  logic [IDX_W-1:0]   ptr,
   output logic               hit,
   output logic [IDX_W-1:0]   sel
);
   generate
      if (PICK_IMPL == 0) begin : g_rotate
         always_comb begin
            hit = 1'b0;
            sel = '0;
            for (int k = 0; k < NUM_SRC; k++) begin
               int j;
               j = int'(ptr) + k;
               if (j >= NUM_SRC) j = j - NUM_SRC;
               if (!hit && pend[j[IDX_W-1:0]]) begin
                  hit = 1'b1;
                  sel = j[IDX_W-1:0];
               end
            end
         end
      end else begin : g_double
         logic [DBL_W-1:0] dbl;
         assign dbl = {pend, pend};
         always_comb begin
            hit = 1'b0;
            sel = '0;
            for (int i = 0; i < DBL_W; i++) begin
               if (!hit && (i >= int'(ptr)) && dbl[i[DBL_IW-1:0]]) begin
                  hit = 1'b1;
                  if (i >= NUM_SRC) sel = IDX_W'(i - NUM_SRC);
                  else              sel = IDX_W'(i);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rr_irq_summary.sv
module rr_irq_summary #(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend,
   output logic               irq_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pend;
   end
endmodule

// File: rtl/rr_irq_agg.sv
module rr_irq_agg #(
   parameter int NUM_SRC   = 32,
   parameter int PICK_IMPL = 0,
   localparam int IDX_W    = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_lvl,
   input  logic               mask_we,
   input  logic [1:0]         mask_op,
   input  logic [NUM_SRC-1:0] mask_wdata,
   output logic [NUM_SRC-1:0] mask_rdata,
   input  logic               dispatch_req,
   output logic               disp_valid,
   output logic               disp_found,
   output logic [IDX_W-1:0]   disp_idx,
   output logic               irq_out
);
   generate
      if (NUM_SRC < 2) begin : g_bad_num
         $error("rr_irq_agg: NUM_SRC must be at least 2");
      end
      if (PICK_IMPL < 0 || PICK_IMPL > 1) begin : g_bad_impl
         $error("rr_irq_agg: PICK_IMPL must be 0 or 1");
      end
   endgenerate

   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] pend;
   logic [IDX_W-1:0]   ptr_q;
   logic [IDX_W-1:0]   ptr_nxt;
   logic               pick_hit;
   logic [IDX_W-1:0]   pick_sel;

   rr_irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (mask_we),
      .op     (mask_op),
      .wdata  (mask_wdata),
      .mask_q (mask_q)
   );

   assign pend       = src_lvl & mask_q;
   assign mask_rdata = mask_q;

   rr_irq_picker #(.NUM_SRC(NUM_SRC), .PICK_IMPL(PICK_IMPL)) u_pick (
      .pend (pend),
      .ptr  (ptr_q),
      .hit  (pick_hit),
      .sel  (pick_sel)
   );

   rr_irq_summary #(.NUM_SRC(NUM_SRC)) u_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend),
      .irq_q (irq_out)
   );

   always_comb begin
      if (pick_sel == IDX_W'(NUM_SRC - 1)) ptr_nxt = '0;
      else                                 ptr_nxt = pick_sel + IDX_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q      <= '0;
         disp_valid <= 1'b0;
         disp_found <= 1'b0;
         disp_idx   <= '0;
      end else begin
         disp_valid <= dispatch_req;
         disp_found <= dispatch_req && pick_hit;
         disp_idx   <= (dispatch_req && pick_hit) ? pick_sel : '0;
         if (dispatch_req && pick_hit) ptr_q <= ptr_nxt;
      end
   end
endmodule

// File: rtl/rr_irq_agg_chk.sv
module rr_irq_agg_chk #(
   parameter int NUM_SRC = 32,
   localparam int IDX_W  = $clog2(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_lvl,
   input logic               mask_we,
   input logic [1:0]         mask_op,
   input logic [NUM_SRC-1:0] mask_wdata,
   input logic [NUM_SRC-1:0] mask_rdata,
   input logic               dispatch_req,
   input logic               disp_valid,
   input logic               disp_found,
   input logic [IDX_W-1:0]   disp_idx,
   input logic               irq_out,
   input logic [IDX_W-1:0]   ptr_q
);
   logic [NUM_SRC-1:0] pend_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_d <= '0;
      else        pend_d <= src_lvl & mask_rdata;
   end

   AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      dispatch_req |=> disp_valid); // R4
   AST_NO_REQ_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !dispatch_req |=> !disp_valid); // R4
   AST_FOUND_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      disp_found |-> pend_d[disp_idx]); // R2
   AST_EMPTY_WAS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_found) |-> (pend_d == '0 && disp_idx == '0)); // R7
   AST_EMPTY_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_found) |-> $stable(ptr_q)); // R7
   AST_PTR_PAST_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      disp_found |-> (ptr_q == ((disp_idx == IDX_W'(NUM_SRC - 1)) ? '0 : disp_idx + IDX_W'(1)))); // R6
   AST_SUMMARY_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == (|pend_d)); // R3
   AST_CLEAR_DROPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_we && mask_op == 2'b10) |=> ((mask_rdata & $past(mask_wdata)) == '0)); // R8
   AST_NOP_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_we || mask_op == 2'b11) |=> $stable(mask_rdata)); // R8
endmodule

bind rr_irq_agg rr_irq_agg_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .src_lvl      (src_lvl),
   .mask_we      (mask_we),
   .mask_op      (mask_op),
   .mask_wdata   (mask_wdata),
   .mask_rdata   (mask_rdata),
   .dispatch_req (dispatch_req),
   .disp_valid   (disp_valid),
   .disp_found   (disp_found),
   .disp_idx     (disp_idx),
   .irq_out      (irq_out),
   .ptr_q        (ptr_q)
);

// File: tb/rr_irq_agg_test.sv
module rr_irq_agg_test;
   localparam int N  = 32;
   localparam int IW = $clog2(N);

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic [N-1:0]  src = '0;
   logic          we = 1'b0;
   logic [1:0]    op = 2'b11;
   logic [N-1:0]  wd = '0;
   logic          req = 1'b0;

   logic [N-1:0]  rd_a, rd_b;
   logic          val_a, val_b, fnd_a, fnd_b, irq_a, irq_b;
   logic [IW-1:0] idx_a, idx_b;

   rr_irq_agg #(.NUM_SRC(N), .PICK_IMPL(0)) uut (
      .clk(clk), .rst_n(rst_n), .src_lvl(src), .mask_we(we), .mask_op(op),
      .mask_wdata(wd), .mask_rdata(rd_a), .dispatch_req(req),
      .disp_valid(val_a), .disp_found(fnd_a), .disp_idx(idx_a), .irq_out(irq_a));

   rr_irq_agg #(.NUM_SRC(N), .PICK_IMPL(1)) uut_alt (
      .clk(clk), .rst_n(rst_n), .src_lvl(src), .mask_we(we), .mask_op(op),
      .mask_wdata(wd), .mask_rdata(rd_b), .dispatch_req(req),
      .disp_valid(val_b), .disp_found(fnd_b), .disp_idx(idx_b), .irq_out(irq_b));

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // behavioural reference
   bit [N-1:0] m_mask  = '0;
   int         m_ptr   = 0;
   bit         m_valid = 1'b0;
   bit         m_found = 1'b0;
   int         m_idx   = 0;
   bit         m_irq   = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mask <= '0; m_ptr <= 0; m_valid <= 1'b0;
         m_found <= 1'b0; m_idx <= 0; m_irq <= 1'b0;
      end else begin : model
         bit [N-1:0] p;
         int pick;
         p = src & m_mask;
         m_irq   <= (p != '0);
         m_valid <= req;
         pick = -1;
         if (req) begin
            for (int k = 0; k < N; k++) begin
               if (pick < 0 && p[(m_ptr + k) % N]) pick = (m_ptr + k) % N;
            end
         end
         m_found <= (pick >= 0);
         m_idx   <= (pick >= 0) ? pick : 0;
         if (pick >= 0) m_ptr <= (pick + 1) % N;
         if (we) begin
            case (op)
               2'b00: m_mask <= wd;
               2'b01: m_mask <= m_mask | wd;
               2'b10: m_mask <= m_mask & ~wd;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!done && rst_n) begin
         chk("R3 irq_out", irq_a, m_irq);
         chk("R3 irq_out alt", irq_b, m_irq);
         chk("R4 disp_valid", val_a, m_valid);
         chk("R4 disp_valid alt", val_b, m_valid);
         chk("R2/R7 disp_found", fnd_a, m_found);
         chk("R2/R7 disp_found alt", fnd_b, m_found);
         chk("R5 disp_idx", idx_a, m_idx);
         chk("R5 disp_idx alt", idx_b, m_idx);
         chk("R8 mask_rdata", rd_a, m_mask);
         chk("R8 mask_rdata alt", rd_b, m_mask);
      end
   end

   task automatic mask_cmd(input logic [1:0] o, input logic [N-1:0] d);
      @(negedge clk);
      we = 1'b1; op = o; wd = d;
      @(negedge clk);
      we = 1'b0; op = 2'b11; wd = '0;
   endtask

   task automatic dispatch(input string tag, input bit exp_f, input int exp_i);
      @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk({tag, " valid"}, val_a, 1);
      chk({tag, " found"}, fnd_a, exp_f);
      chk({tag, " index"}, idx_a, exp_i);
      chk({tag, " index alt"}, idx_b, exp_i);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 mask", rd_a, 0);
      chk("R1 irq", irq_a, 0);
      chk("R1 valid", val_a, 0);
      chk("R1 found", fnd_a, 0);
      chk("R1 idx", idx_a, 0);
      rst_n = 1'b1;

      mask_cmd(2'b00, '1);
      chk("R8 load all", rd_a, 32'hFFFF_FFFF);
      src = (N'(1) << 3) | (N'(1) << 7) | (N'(1) << 20);
      repeat (2) @(negedge clk);
      chk("R3 irq raised", irq_a, 1);
      dispatch("R1/R5 first from ptr 0", 1, 3);
      dispatch("R6 next", 1, 7);
      dispatch("R6 next", 1, 20);
      dispatch("R6 wrap to 3", 1, 3);

      mask_cmd(2'b10, N'(1) << 7);
      chk("R8 clear one bit", rd_a, 32'hFFFF_FF7F);
      dispatch("R2 masked 7 skipped", 1, 20);
      mask_cmd(2'b11, '1);
      chk("R8 nop op", rd_a, 32'hFFFF_FF7F);
      mask_cmd(2'b01, N'(1) << 7);
      chk("R8 set one bit", rd_a, 32'hFFFF_FFFF);

      src = (N'(1) << 31) | N'(1);
      dispatch("R5 top index", 1, 31);
      dispatch("R6 31 wraps to 0", 1, 0);
      src = '0;
      dispatch("R7 empty", 0, 0);
      src = (N'(1) << 5) | (N'(1) << 2);
      dispatch("R7 ptr kept at 1", 1, 2);

      @(negedge clk);
      src = N'(1) << 9;
      @(negedge clk);
      src = '0;
      dispatch("R9 dropped line not latched", 0, 0);

      mask_cmd(2'b00, '0);
      src = '1;
      repeat (2) @(negedge clk);
      chk("R2 all masked irq", irq_a, 0);
      dispatch("R2 all masked dispatch", 0, 0);

      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         src = $urandom & $urandom & $urandom;
         we  = ($urandom % 6) == 0;
         op  = 2'($urandom);
         wd  = $urandom;
         req = ($urandom % 3) == 0;
      end
      @(negedge clk);
      we = 1'b0; req = 1'b0;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog R4 actual=hung expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule